// File: doc/BRIEF.md
# Linked Structure Prefetch Unroller

This block replays stored descriptions of pointer-chasing loops as a stream of prefetch addresses. Each description is keyed by the program counter of the load that starts the traversal. It holds a rule of one to four steps, each step being a byte offset and a look-back distance, and a repetition count. When a retiring load's PC hits a stored description, the value that load returned becomes the root of a walk. Each prefetch then forms its address by taking the value that came back for an earlier position of the same walk and adding the step offset.

The walk sequence numbers its positions. The root is position 0 and the k-th prefetch is position k. Position k uses rule step (k-1) mod steps. A step with distance d takes as its base the value of position k-d. Because the bases are returned prefetch data, the rule follows a chain of `next` pointers from one node to the next. The repetition count bounds the walk, and a null base ends it early. Memory responses come back in issue order. The block keeps the last four returned values, so each step waits only for the particular value it depends on.

A small finite-state machine controls the walk. In IDLE it watches for a trigger: a start moves it to RUN. In RUN it issues steps. When the final step is accepted, or a null base is met, it goes to IDLE if no response is outstanding and to DRAIN otherwise. DRAIN waits for the last response and then returns to IDLE.

Top module: `lsp_unroller`

## Requirements
- R1: After reset no prefetch is requested and the description table is empty, so no load can start a walk until a description has been written.
- R2: A walk starts only when `ld_valid` is high and `ld_pc` equals the PC of a stored description. A load whose PC matches no entry has no effect.
- R3: The table holds 4 entries. Writing a PC that is already stored replaces that entry in place. Writing a new PC fills slots in round-robin order, so the fifth distinct PC evicts the first.
- R4: A description write encodes step i as offset `rw_offs[8i+7:8i]` (unsigned bytes) and distance minus one in `rw_backs[2i+1:2i]`, with `rw_last` = steps - 1. The prefetch for position k is the value of position k-d plus the offset of step (k-1) mod steps. The root value is position 0.
- R5: A walk issues at most `rw_loops` × steps prefetches. A stored repetition count of zero starts no walk.
- R6: A step is not requested until the value of the position it depends on has returned. A step whose base has already returned is requested in the cycle after the previous handshake, so independent steps issue back to back.
- R7: A walk ends without requesting the step when that step's base value is zero. Positions before the root read as zero.
- R8: A trigger that arrives while a walk is running or responses are still outstanding is ignored.
- R9: While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_addr` holds its value.
- R10: The first prefetch of a walk is offered in the cycle after the triggering load is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rw_valid | input | 1 | Write one description |
| rw_pc | input | PC_W | PC key of the description |
| rw_loops | input | 4 | Repetition count |
| rw_last | input | 2 | Number of steps minus one |
| rw_offs | input | 32 | Four 8-bit step offsets, step 0 in the low byte |
| rw_backs | input | 8 | Four 2-bit distances minus one, step 0 in the low bits |
| ld_valid | input | 1 | Retired load present |
| ld_pc | input | PC_W | PC of the retired load |
| ld_value | input | ADDR_W | Value the load returned (walk root) |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Prefetch request accepted |
| pf_addr | output | ADDR_W | Prefetch address |
| rsp_valid | input | 1 | Prefetch data returned (in issue order) |
| rsp_data | input | ADDR_W | Returned data |

## Verification
The linked-list rule (offsets 0, 4, 8; distances 1, 2, 3) is replayed over a memory in which each node points to the next. This separates the step indexing and the look-back selection from plain sequential fetching. A single-step chain with a long response latency shows that the block stalls on a dependency. The list rule with the ready line always high shows that independent steps issue back to back, and with the ready line toggling it shows that a request is held until accepted. Further walks cover a null pointer in the chain, a distance that reaches before the root, a zero root, and a zero repetition count, which tell early termination apart from normal completion. Table writes that rewrite a PC in place and that evict by round robin, together with triggers sent in the middle of a walk, tell replacement and trigger filtering apart from the walk itself.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

    localparam int OFF_W   = 8;
    localparam int N_STEPS = 4;
    localparam int STEP_W  = $clog2(N_STEPS);
    localparam int LOOP_W  = 4;
    localparam int OUT_W   = STEP_W + 1;

    typedef struct packed {
        logic [OFF_W-1:0]  off;
        logic [STEP_W-1:0] back;   // distance minus one
    } step_t;

    typedef struct packed {
        logic [LOOP_W-1:0]        loops;
        logic [STEP_W-1:0]        last;
        step_t [N_STEPS-1:0]      steps;
    } rule_t;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_RUN   = 2'd1,
        W_DRAIN = 2'd2
    } walk_state_t;

endpackage

// File: rtl/lsp_rep_table.sv
module lsp_rep_table
    import lsp_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int PC_W    = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_pc,
    input  rule_t           wr_rule,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output rule_t           lk_rule
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] wr_match;
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] ent_vld;
    rule_t              ent_rule [ENTRIES];
    logic [IDX_W-1:0]   rr_ptr;
    logic [IDX_W-1:0]   wr_sel;
    logic               wr_any;

    // Per-entry storage and compare
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic            vld_q;
        logic [PC_W-1:0] pc_q;
        rule_t           rule_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
            end else if (wr_en && (wr_sel == IDX_W'(g))) begin
                vld_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && (wr_sel == IDX_W'(g))) begin
                pc_q   <= wr_pc;
                rule_q <= wr_rule;
            end
        end

        assign ent_vld[g]  = vld_q;
        assign ent_rule[g] = rule_q;
        assign wr_match[g] = vld_q && (pc_q == wr_pc);
        assign lk_match[g] = vld_q && (pc_q == lk_pc);
    end

    // Write slot: matching entry in place, else round-robin slot
    always_comb begin
        wr_any = 1'b0;
        wr_sel = rr_ptr;
        for (int i = 0; i < ENTRIES; i++) begin
            if (wr_match[i]) begin
                wr_any = 1'b1;
                wr_sel = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (wr_en && !wr_any) begin
            rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end

    // Lookup
    always_comb begin
        lk_hit  = 1'b0;
        lk_rule = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                lk_hit  = 1'b1;
                lk_rule = ent_rule[i];
            end
        end
    end

    // R3
    uniq_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R3
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ent_vld[$past(wr_sel)]);

    // R3
    rr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_any) |=> (rr_ptr != $past(rr_ptr)));

    // R3
    rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_any) |=> $stable(rr_ptr));

endmodule

// File: rtl/lsp_hist.sv
module lsp_hist #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 4,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] root,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_val,
    input  logic [SEL_W-1:0]  sel,
    output logic [ADDR_W-1:0] base
);

    // h_q[0] holds the newest known position, h_q[j] the one j positions older
    logic [ADDR_W-1:0] h_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                h_q[i] <= '0;
            end
        end else if (load) begin
            h_q[0] <= root;
            for (int i = 1; i < DEPTH; i++) begin
                h_q[i] <= '0;
            end
        end else if (push) begin
            h_q[0] <= push_val;
            for (int i = 1; i < DEPTH; i++) begin
                h_q[i] <= h_q[i-1];
            end
        end
    end

    assign base = h_q[sel];

    // R4
    load_root_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (h_q[0] == $past(root)));

    // R7
    load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (h_q[DEPTH-1] == '0));

    // R6
    push_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !load) |=> (h_q[1] == $past(h_q[0])) && (h_q[0] == $past(push_val)));

endmodule

// File: rtl/lsp_walk_ctl.sv
module lsp_walk_ctl
    import lsp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  rule_t             trig_rule,
    input  logic              rsp_valid,
    input  logic [ADDR_W-1:0] base,
    input  logic              pf_ready,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr,
    output logic              hist_load,
    output logic [STEP_W-1:0] hist_sel
);

    walk_state_t        state_q, state_nx;
    rule_t              rule_q;
    logic [STEP_W-1:0]  step_q;
    logic [LOOP_W-1:0]  loop_q;
    logic [OUT_W-1:0]   out_q, out_nx;

    step_t              cur_step;
    logic               elig;
    logic               base_nz;
    logic               start;
    logic               fire;
    logic               null_hit;
    logic               last_step;

    // Decode of the current step
    always_comb begin
        cur_step  = rule_q.steps[step_q];
        elig      = (out_q <= OUT_W'(cur_step.back));
        base_nz   = (base != '0);
        last_step = (step_q == rule_q.last) &&
                    (loop_q == rule_q.loops - LOOP_W'(1));
        start     = (state_q == W_IDLE) && trig && (trig_rule.loops != '0);
        null_hit  = (state_q == W_RUN) && elig && !base_nz;
    end

    // Output process
    always_comb begin
        hist_sel  = cur_step.back - out_q[STEP_W-1:0];
        hist_load = start;
        pf_valid  = (state_q == W_RUN) && elig && base_nz;
        pf_addr   = base + ADDR_W'(cur_step.off);
        fire      = pf_valid && pf_ready;
        out_nx    = out_q + OUT_W'(fire) - OUT_W'(rsp_valid);
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            W_IDLE: begin
                if (start) begin
                    state_nx = W_RUN;
                end
            end
            W_RUN: begin
                if (null_hit || (fire && last_step)) begin
                    state_nx = (out_nx == '0) ? W_IDLE : W_DRAIN;
                end
            end
            W_DRAIN: begin
                if (out_nx == '0) begin
                    state_nx = W_IDLE;
                end
            end
            default: begin
                state_nx = W_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Walk position and outstanding count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rule_q <= '0;
            step_q <= '0;
            loop_q <= '0;
            out_q  <= '0;
        end else begin
            out_q <= out_nx;
            if (start) begin
                rule_q <= trig_rule;
                step_q <= '0;
                loop_q <= '0;
            end else if (fire) begin
                if (step_q == rule_q.last) begin
                    step_q <= '0;
                    loop_q <= loop_q + LOOP_W'(1);
                end else begin
                    step_q <= step_q + STEP_W'(1);
                end
            end
        end
    end

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

    // R6
    out_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_q <= OUT_W'(N_STEPS));

    // R10
    start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state_q == W_RUN));

    // R5
    last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && last_step) |=> (state_q != W_RUN));

    // R7
    null_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        null_hit |=> (state_q != W_RUN));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_IDLE) |-> (out_q == '0));

    // R8
    busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != W_IDLE) && !fire) |=> $stable(step_q) && $stable(loop_q));

endmodule

// File: rtl/lsp_unroller.sv
module lsp_unroller
    import lsp_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int PC_W    = 32,
    parameter int ENTRIES = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rw_valid,
    input  logic [PC_W-1:0]            rw_pc,
    input  logic [LOOP_W-1:0]          rw_loops,
    input  logic [STEP_W-1:0]          rw_last,
    input  logic [N_STEPS*OFF_W-1:0]   rw_offs,
    input  logic [N_STEPS*STEP_W-1:0]  rw_backs,
    input  logic                       ld_valid,
    input  logic [PC_W-1:0]            ld_pc,
    input  logic [ADDR_W-1:0]          ld_value,
    output logic                       pf_valid,
    input  logic                       pf_ready,
    output logic [ADDR_W-1:0]          pf_addr,
    input  logic                       rsp_valid,
    input  logic [ADDR_W-1:0]          rsp_data
);

    rule_t              wr_rule;
    rule_t              lk_rule;
    logic               lk_hit;
    logic               hist_load;
    logic [STEP_W-1:0]  hist_sel;
    logic [ADDR_W-1:0]  base;

    always_comb begin
        wr_rule.loops = rw_loops;
        wr_rule.last  = rw_last;
        for (int i = 0; i < N_STEPS; i++) begin
            wr_rule.steps[i].off  = rw_offs[i*OFF_W +: OFF_W];
            wr_rule.steps[i].back = rw_backs[i*STEP_W +: STEP_W];
        end
    end

    lsp_rep_table #(
        .ENTRIES (ENTRIES),
        .PC_W    (PC_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rw_valid),
        .wr_pc   (rw_pc),
        .wr_rule (wr_rule),
        .lk_pc   (ld_pc),
        .lk_hit  (lk_hit),
        .lk_rule (lk_rule)
    );

    lsp_hist #(
        .ADDR_W (ADDR_W),
        .DEPTH  (N_STEPS),
        .SEL_W  (STEP_W)
    ) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hist_load),
        .root     (ld_value),
        .push     (rsp_valid),
        .push_val (rsp_data),
        .sel      (hist_sel),
        .base     (base)
    );

    lsp_walk_ctl #(
        .ADDR_W (ADDR_W)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (ld_valid && lk_hit),
        .trig_rule (lk_rule),
        .rsp_valid (rsp_valid),
        .base      (base),
        .pf_ready  (pf_ready),
        .pf_valid  (pf_valid),
        .pf_addr   (pf_addr),
        .hist_load (hist_load),
        .hist_sel  (hist_sel)
    );

    // R1
    no_req_in_reset_chk: assert property (@(posedge clk)
        !rst_n |-> !pf_valid);

endmodule

// File: tb/lsp_unroller_bench.sv
module lsp_unroller_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rw_valid = 1'b0;
    logic [31:0] rw_pc = '0;
    logic [3:0]  rw_loops = '0;
    logic [1:0]  rw_last = '0;
    logic [31:0] rw_offs = '0;
    logic [7:0]  rw_backs = '0;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_pc = '0;
    logic [31:0] ld_value = '0;
    logic        pf_valid;
    logic        pf_ready = 1'b1;
    logic [31:0] pf_addr;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsp_unroller u_lsp_unroller (
        .clk(clk), .rst_n(rst_n),
        .rw_valid(rw_valid), .rw_pc(rw_pc), .rw_loops(rw_loops), .rw_last(rw_last),
        .rw_offs(rw_offs), .rw_backs(rw_backs),
        .ld_valid(ld_valid), .ld_pc(ld_pc), .ld_value(ld_value),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    int    errs = 0;
    int    checks = 0;
    int    cyc = 0;
    int    lat = 2;
    bit    done_flag = 1'b0;
    string cur_req = "R1";

    // reference table
    logic [31:0] t_pc [NE];
    bit          t_vld [NE];
    int          t_loops [NE];
    int          t_n [NE];
    int          t_off [NE][4];
    int          t_back [NE][4];
    int          t_rr = 0;

    // reference walk
    bit          m_run = 1'b0;
    logic [31:0] m_vals [$];
    int          m_iss = 0;
    int          m_ret = 0;
    int          m_total = 0;
    int          w_n = 1;
    int          w_off [4];
    int          w_back [4];

    // memory responder and handshake log
    logic [31:0] rq_addr [$];
    int          rq_cyc [$];
    logic [31:0] hs_log [$];
    int          hs_cyc [$];
    logic [31:0] mem [logic [31:0]];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] memfn(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return a + 32'h100;
    endfunction

    function automatic bit m_idle();
        return !m_run && (m_iss == m_ret) && (rq_addr.size() == 0);
    endfunction

    task automatic predict(output bit v, output logic [31:0] a, output bit nul);
        int k, d, src, s;
        logic [31:0] b;
        v = 1'b0; a = '0; nul = 1'b0;
        if (m_run) begin
            k   = m_iss + 1;
            s   = (k - 1) % w_n;
            d   = w_back[s];
            src = k - d;
            if (src <= m_ret) begin
                b = (src < 0) ? 32'h0 : m_vals[src];
                if (b == 32'h0) nul = 1'b1;
                else begin
                    v = 1'b1;
                    a = b + 32'(w_off[s]);
                end
            end
        end
    endtask

    // One cycle: drive response, compare outputs, advance the reference
    task automatic step();
        bit          pv, pn, idle0;
        logic [31:0] pa;
        int          hit, slot;
        rsp_valid = 1'b0;
        rsp_data  = '0;
        if (rq_addr.size() > 0 && (cyc - rq_cyc[0]) >= lat) begin
            rsp_valid = 1'b1;
            rsp_data  = memfn(rq_addr[0]);
            void'(rq_addr.pop_front());
            void'(rq_cyc.pop_front());
        end
        predict(pv, pa, pn);
        chk(pf_valid === pv, cur_req, "pf_valid", longint'(pf_valid), longint'(pv));
        if (pv && pf_valid) chk(pf_addr === pa, cur_req, "pf_addr", pf_addr, pa);
        if (pf_valid && pf_ready) begin
            rq_addr.push_back(pf_addr);
            rq_cyc.push_back(cyc);
            hs_log.push_back(pf_addr);
            hs_cyc.push_back(cyc);
        end
        idle0 = !m_run && (m_iss == m_ret);
        if (rsp_valid) begin
            m_vals.push_back(rsp_data);
            m_ret++;
        end
        if (m_run) begin
            if (pn) m_run = 1'b0;
            else if (pv && pf_ready) begin
                m_iss++;
                if (m_iss == m_total) m_run = 1'b0;
            end
        end else if (idle0 && ld_valid) begin
            hit = -1;
            for (int i = 0; i < NE; i++) if (t_vld[i] && t_pc[i] == ld_pc) hit = i;
            if (hit >= 0 && t_loops[hit] != 0) begin
                m_run = 1'b1;
                m_vals.delete();
                m_vals.push_back(ld_value);
                m_iss = 0;
                m_ret = 0;
                w_n = t_n[hit];
                m_total = t_loops[hit] * t_n[hit];
                for (int i = 0; i < 4; i++) begin
                    w_off[i]  = t_off[hit][i];
                    w_back[i] = t_back[hit][i];
                end
            end
        end
        if (rw_valid) begin
            slot = -1;
            for (int i = 0; i < NE; i++) if (t_vld[i] && t_pc[i] == rw_pc) slot = i;
            if (slot < 0) begin
                slot = t_rr;
                t_rr = (t_rr + 1) % NE;
            end
            t_vld[slot]   = 1'b1;
            t_pc[slot]    = rw_pc;
            t_loops[slot] = int'(rw_loops);
            t_n[slot]     = int'(rw_last) + 1;
            for (int i = 0; i < 4; i++) begin
                t_off[slot][i]  = int'(rw_offs[i*8 +: 8]);
                t_back[slot][i] = int'(rw_backs[i*2 +: 2]) + 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        cyc++;
    endtask

    task automatic write_rep(input logic [31:0] pc, input int loops, input int n,
                             input int o0, input int o1, input int o2, input int o3,
                             input int b0, input int b1, input int b2, input int b3);
        rw_valid = 1'b1;
        rw_pc    = pc;
        rw_loops = 4'(loops);
        rw_last  = 2'(n - 1);
        rw_offs  = {8'(o3), 8'(o2), 8'(o1), 8'(o0)};
        rw_backs = {2'(b3 - 1), 2'(b2 - 1), 2'(b1 - 1), 2'(b0 - 1)};
        pf_ready = 1'b1;
        step();
        rw_valid = 1'b0;
    endtask

    task automatic fire_load(input logic [31:0] pc, input logic [31:0] val);
        ld_valid = 1'b1;
        ld_pc    = pc;
        ld_value = val;
        step();
        ld_valid = 1'b0;
    endtask

    task automatic run_idle(input int rdy_pat);
        int n;
        n = 0;
        while (!m_idle() && n < 3000) begin
            pf_ready = (rdy_pat == 0) ? 1'b1 : ((cyc % 3) != 0);
            step();
            n++;
        end
        pf_ready = 1'b1;
        chk(n < 3000, cur_req, "walk completes", n, 3000);
        repeat (2) step();
    endtask

    task automatic walk(input logic [31:0] pc, input logic [31:0] root, input int rdy_pat);
        hs_log.delete();
        hs_cyc.delete();
        fire_load(pc, root);
        run_idle(rdy_pat);
    endtask

    initial begin
        logic [31:0] exp_list [9];
        exp_list = '{32'h1000, 32'h1004, 32'h1008, 32'h2500, 32'h2504,
                     32'h2508, 32'h3000, 32'h3004, 32'h3008};
        for (int i = 0; i < NE; i++) t_vld[i] = 1'b0;
        mem[32'h1008] = 32'h2500;
        mem[32'h2508] = 32'h3000;

        // R1: reset state and empty table
        repeat (3) @(negedge clk);
        chk(pf_valid === 1'b0, "R1", "pf_valid in reset", longint'(pf_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        walk(32'h118, 32'h1000, 0);
        chk(hs_log.size() == 0, "R1", "prefetches with empty table", hs_log.size(), 0);

        // R4 / R10 / R6: list rule, ready always high
        cur_req = "R4";
        write_rep(32'h118, 3, 3, 0, 4, 8, 0, 1, 2, 3, 1);
        hs_log.delete();
        hs_cyc.delete();
        fire_load(32'h118, 32'h1000);
        chk(pf_valid === 1'b1, "R10", "first request after trigger", longint'(pf_valid), 1);
        run_idle(0);
        chk(hs_log.size() == 9, "R5", "prefetch count loops*steps", hs_log.size(), 9);
        for (int i = 0; i < 9 && i < hs_log.size(); i++)
            chk(hs_log[i] == exp_list[i], "R4", "list address", hs_log[i], exp_list[i]);
        if (hs_cyc.size() >= 4) begin
            chk(hs_cyc[1] == hs_cyc[0] + 1, "R6", "back-to-back step 2", hs_cyc[1] - hs_cyc[0], 1);
            chk(hs_cyc[2] == hs_cyc[0] + 2, "R6", "back-to-back step 3", hs_cyc[2] - hs_cyc[0], 2);
            chk(hs_cyc[3] > hs_cyc[2] + 1, "R6", "dependent step waits", hs_cyc[3] - hs_cyc[2], 2);
        end

        // R9: ready toggling, longer latency
        cur_req = "R9";
        lat = 3;
        walk(32'h118, 32'h1000, 1);
        chk(hs_log.size() == 9, "R9", "count under backpressure", hs_log.size(), 9);
        if (hs_log.size() == 9)
            chk(hs_log[8] == 32'h3008, "R9", "final address", hs_log[8], 32'h3008);

        // R6: single-step pointer chase, spacing equals latency plus one
        cur_req = "R6";
        lat = 4;
        write_rep(32'h200, 4, 1, 0, 0, 0, 0, 1, 1, 1, 1);
        walk(32'h200, 32'h6000, 0);
        chk(hs_log.size() == 4, "R6", "chain count", hs_log.size(), 4);
        if (hs_log.size() == 4) begin
            chk(hs_log[3] == 32'h6300, "R6", "chain address", hs_log[3], 32'h6300);
            chk(hs_cyc[1] - hs_cyc[0] == lat + 1, "R6", "chain spacing", hs_cyc[1] - hs_cyc[0], lat + 1);
        end
        lat = 2;

        // R7: null pointer, pre-root distance, zero root
        cur_req = "R7";
        mem[32'h3008] = 32'h0;
        write_rep(32'h204, 5, 3, 0, 4, 8, 0, 1, 2, 3, 1);
        walk(32'h204, 32'h1000, 0);
        chk(hs_log.size() == 9, "R7", "walk stops at null", hs_log.size(), 9);
        write_rep(32'h300, 3, 1, 0, 0, 0, 0, 2, 1, 1, 1);
        walk(32'h300, 32'h1000, 0);
        chk(hs_log.size() == 0, "R7", "distance before root", hs_log.size(), 0);
        walk(32'h200, 32'h0, 0);
        chk(hs_log.size() == 0, "R7", "zero root", hs_log.size(), 0);

        // R8: trigger during a walk ignored
        cur_req = "R8";
        lat = 5;
        hs_log.delete();
        hs_cyc.delete();
        fire_load(32'h118, 32'h1000);
        repeat (4) step();
        fire_load(32'h200, 32'h8000);
        run_idle(0);
        chk(hs_log.size() == 9, "R8", "mid-walk trigger ignored", hs_log.size(), 9);
        lat = 2;

        // R2: unknown PC
        cur_req = "R2";
        walk(32'h999, 32'h1000, 0);
        chk(hs_log.size() == 0, "R2", "unmatched PC", hs_log.size(), 0);

        // R3: in-place rewrite, then round-robin eviction
        cur_req = "R3";
        write_rep(32'h118, 1, 1, 0, 0, 0, 0, 1, 1, 1, 1);
        walk(32'h118, 32'h7000, 0);
        chk(hs_log.size() == 1, "R3", "rewrite in place", hs_log.size(), 1);
        write_rep(32'h400, 2, 2, 0, 4, 0, 0, 1, 2, 1, 1);
        walk(32'h118, 32'h7000, 0);
        chk(hs_log.size() == 0, "R3", "oldest slot evicted", hs_log.size(), 0);
        walk(32'h204, 32'h1000, 0);
        chk(hs_log.size() == 9, "R3", "other entry kept", hs_log.size(), 9);
        walk(32'h400, 32'h5000, 0);
        chk(hs_log.size() == 4, "R3", "new entry walks", hs_log.size(), 4);

        // R5: zero repetition count
        cur_req = "R5";
        write_rep(32'h500, 0, 1, 0, 0, 0, 0, 1, 1, 1, 1);
        walk(32'h500, 32'h1000, 0);
        chk(hs_log.size() == 0, "R5", "zero loops", hs_log.size(), 0);

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done_flag) begin
            errs++;
            checks++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule